// File: doc/BRIEF.md
# Prescaled PWM Timer with APB Register Port

This block is a memory-mapped timer. Software reaches it through an APB completer port and programs six word registers: an enable, a clock divider, a terminal count, a PWM threshold, a preset value, and a load command. While enabled, an up-counter advances once every divider period. It returns to zero on the advance after it reaches the terminal count. A PWM pin compares the live count against the threshold, and a one-cycle interrupt pulse marks each advance that lands on the terminal count.

There is no streaming data path. The APB port is the only handshake, and it never applies back-pressure: the completer-ready signal is tied high, so every access ends in its access phase with no wait states. The count, PWM level and interrupt pulse are plain output pins.

Register word offsets: 0x00 enable (bit 0), 0x04 divider, 0x08 terminal count, 0x0C PWM threshold, 0x10 preset value, 0x14 load command (write-only strobe).

Top module: `apb_pwm_timer`

## Requirements
- R1: After reset, all registers read 0, the count is 0, and the PWM and interrupt outputs are low.
- R2: A write happens when psel, penable and pwrite are all high, and it updates the register at its word offset in that clock edge. A read (psel and penable high, pwrite low) returns the register zero-extended. Reads of unmapped offsets return 0, and writes to them do nothing. pready is always 1.
- R3: While enable bit 0 at offset 0x00 is 0, the count holds its value and the divider phase restarts from zero.
- R4: A divider value of 0 or 1 at 0x04 advances the count on every enabled clock. A value N greater than 1 advances it on every Nth enabled clock, and the first advance comes N clocks after enable is set.
- R5: An advance adds one to the count. If the count is at or above the terminal count at 0x08, the advance sets the count to 0 instead.
- R6: The interrupt output is high for exactly the cycle in which the count holds the terminal count because an advance just placed it there.
- R7: The PWM output is high exactly when count < threshold (0x0C). A threshold of 0 keeps it low, and a threshold above the terminal count keeps it high.
- R8: Writing 0x14 with bit 0 set loads the count with the preset register (0x10) at that write's clock edge. Offset 0x14 reads as 0.
- R9: In a cycle where a load and an advance coincide, the load wins. A load never raises the interrupt, even when the preset equals the terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, always 1 |
| count_o | output | CNT_W | Current count |
| pwm_o | output | 1 | PWM level |
| irq_o | output | 1 | Terminal-count pulse |

## Verification
The inline assertions check these properties on every cycle: the count stays put when it does not advance, wrap always goes to zero, a load takes the preset and raises no interrupt, the interrupt only ever coincides with the terminal count, the PWM obeys its two threshold extremes, and the load offset reads as zero. The bench's scenarios are needed for the properties that depend on a sequence of cycles: the exact divider period, the number of interrupt pulses over a window, register read-back, and whether a load wins over a coinciding advance. A cycle-level reference model in the bench covers these across directed and random register traffic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_EN     = 3'd0,
    SEL_DIV    = 3'd1,
    SEL_TERM   = 3'd2,
    SEL_THRESH = 3'd3,
    SEL_PRESET = 3'd4,
    SEL_LOAD   = 3'd5,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 6;

  function automatic reg_sel_e word_to_sel(input logic [2:0] word);
    reg_sel_e s;
    case (word)
      3'd0: s = SEL_EN;
      3'd1: s = SEL_DIV;
      3'd2: s = SEL_TERM;
      3'd3: s = SEL_THRESH;
      3'd4: s = SEL_PRESET;
      3'd5: s = SEL_LOAD;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  term_q,
  output logic [CNT_W-1:0]  thresh_q,
  output logic [CNT_W-1:0]  preset_q,
  output logic              load_stb
);
  reg_sel_e sel;
  logic     aligned, hi_zero, wr_acc, rd_acc;

  assign aligned = (paddr[1:0] == 2'b00);
  assign hi_zero = ((paddr >> 5) == '0);
  assign wr_acc  = psel && penable && pwrite;
  assign rd_acc  = psel && penable && !pwrite;

  always_comb begin
    sel = SEL_NONE;
    if (aligned && hi_zero) sel = word_to_sel(paddr[4:2]);
  end

  assign load_stb = wr_acc && (sel == SEL_LOAD) && pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      div_q    <= '0;
      term_q   <= '0;
      thresh_q <= '0;
      preset_q <= '0;
    end else if (wr_acc) begin
      case (sel)
        SEL_EN:     en_q     <= pwdata[0];
        SEL_DIV:    div_q    <= pwdata[DIV_W-1:0];
        SEL_TERM:   term_q   <= pwdata[CNT_W-1:0];
        SEL_THRESH: thresh_q <= pwdata[CNT_W-1:0];
        SEL_PRESET: preset_q <= pwdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      case (sel)
        SEL_EN:     prdata = DATA_W'(en_q);
        SEL_DIV:    prdata = DATA_W'(div_q);
        SEL_TERM:   prdata = DATA_W'(term_q);
        SEL_THRESH: prdata = DATA_W'(thresh_q);
        SEL_PRESET: prdata = DATA_W'(preset_q);
        default:    prdata = '0;
      endcase
    end
  end

  // R8
  load_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && sel == SEL_LOAD) |-> (prdata == '0));

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel == SEL_EN) |=> (en_q == $past(pwdata[0])));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;
  logic [DIV_W:0]   phase_inc, period;

  assign phase_inc = {1'b0, phase} + 1'b1;
  assign period    = (div <= DIV_W'(1)) ? (DIV_W+1)'(1) : {1'b0, div};
  assign tick      = en && (phase_inc >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (!en)    phase <= '0;
    else if (tick)   phase <= '0;
    else             phase <= phase_inc[DIV_W-1:0];
  end

  // R4
  tick_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);

  // R3
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  logic [CNT_W-1:0] nxt;

  assign nxt = (cnt >= term) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (load) begin
      cnt <= preset;
      irq <= 1'b0;
    end else if (tick) begin
      cnt <= nxt;
      irq <= (nxt == term);
    end else begin
      irq <= 1'b0;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt >= term) |=> (cnt == '0));

  // R6
  irq_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == $past(term)));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(preset) && !irq));
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] term,
  output logic             pwm
);
  assign pwm = (cnt < thresh);

  // R7
  zero_thresh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) |-> !pwm);

  // R7
  high_thresh_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh > term && cnt <= term) |-> pwm);
endmodule

// File: rtl/apb_pwm_timer.sv
module apb_pwm_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_o,
  output logic              irq_o
);
  logic             en_q, load_stb, tick;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] term_q, thresh_q, preset_q;

  assign pready = 1'b1;

  tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .en_q(en_q), .div_q(div_q),
    .term_q(term_q), .thresh_q(thresh_q), .preset_q(preset_q), .load_stb(load_stb)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en_q), .div(div_q), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_stb), .preset(preset_q),
    .term(term_q), .cnt(count_o), .irq(irq_o)
  );

  tmr_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .cnt(count_o), .thresh(thresh_q), .term(term_q),
    .pwm(pwm_o)
  );
endmodule

// File: tb/apb_pwm_timer_tb.sv
module apb_pwm_timer_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          pready;
  logic [CW-1:0] count_o;
  logic          pwm_o, irq_o;

  int checks = 0, fails = 0;
  int irq_seen = 0, pwm_high = 0;
  bit done = 0;

  // reference model state
  int m_en, m_div, m_term, m_thresh, m_preset, m_cnt, m_irq, m_phase;

  always #10 clk = ~clk;

  apb_pwm_timer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .DIV_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .count_o(count_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_reg(input int a);
    case (a)
      'h00: return m_en;
      'h04: return m_div;
      'h08: return m_term;
      'h0C: return m_thresh;
      'h10: return m_preset;
      default: return 0;
    endcase
  endfunction

  // cycle model derived from R3..R9, applied at each rising edge
  always @(posedge clk) begin
    int period, nxt;
    bit tk, ld, wr;
    if (!rst_n) begin
      m_en = 0; m_div = 0; m_term = 0; m_thresh = 0; m_preset = 0;
      m_cnt = 0; m_irq = 0; m_phase = 0;
    end else begin
      wr = psel && penable && pwrite;
      ld = wr && paddr == 8'h14 && pwdata[0];
      period = (m_div <= 1) ? 1 : m_div;
      tk = (m_en != 0) && (m_phase + 1 >= period);
      if (m_en == 0 || tk) m_phase = 0; else m_phase = m_phase + 1;
      if (ld) begin
        m_cnt = m_preset; m_irq = 0;
      end else if (tk) begin
        nxt = (m_cnt >= m_term) ? 0 : m_cnt + 1;
        m_cnt = nxt; m_irq = (nxt == m_term);
      end else m_irq = 0;
      if (wr) case (paddr)
        8'h00: m_en = int'(pwdata[0]);
        8'h04: m_div = int'(pwdata[PW-1:0]);
        8'h08: m_term = int'(pwdata[CW-1:0]);
        8'h0C: m_thresh = int'(pwdata[CW-1:0]);
        8'h10: m_preset = int'(pwdata[CW-1:0]);
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(count_o) == m_cnt, "R3/R5 count", int'(count_o), m_cnt);
      chk(pwm_o == (m_cnt < m_thresh), "R7 pwm", int'(pwm_o), int'(m_cnt < m_thresh));
      chk(int'(irq_o) == m_irq, "R6 irq", int'(irq_o), m_irq);
      if (irq_o) irq_seen++;
      if (pwm_o) pwm_high++;
    end
  end

  task automatic apb_write(input int a, input int d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = AW'(a); pwdata = DW'(d);
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input int a, input string tag);
    int exp;
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = AW'(a);
    @(negedge clk);
    penable = 1;
    exp = model_reg(a);
    #1;
    chk(pready == 1'b1, "R2 pready", int'(pready), 1);
    chk(prdata == DW'(exp), tag, int'(prdata), exp);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int held, a;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(count_o == '0, "R1 count", int'(count_o), 0);
    chk(!pwm_o && !irq_o, "R1 outputs", int'(pwm_o) + int'(irq_o), 0);
    for (int i = 0; i < 6; i++) apb_read(i * 4, "R1 reg reset");

    // R2 read-back and unmapped offsets, R8 load offset reads 0
    apb_write('h08, 'h1F5); apb_write('h0C, 'h77); apb_write('h10, 'h33);
    apb_write('h04, 'h302); apb_write('h18, 'hFF);
    apb_read('h08, "R2 term readback"); apb_read('h0C, "R2 thresh readback");
    apb_read('h10, "R2 preset readback"); apb_read('h04, "R2 div readback");
    apb_read('h18, "R2 unmapped read"); apb_read('h02, "R2 misaligned read");
    apb_read('h14, "R8 load reads zero");

    // R6 pulses with divider 0: period of term+1 cycles
    apb_write('h04, 0); apb_write('h08, 5); apb_write('h0C, 3); apb_write('h00, 1);
    idle(3);
    irq_seen = 0; idle(24);
    chk(irq_seen == 4, "R6 irq pulses div0", irq_seen, 4);
    // R4 divider 1 behaves as 0
    apb_write('h04, 1); idle(2);
    irq_seen = 0; idle(24);
    chk(irq_seen == 4, "R4 irq pulses div1", irq_seen, 4);
    // R4 divider 3: 18-cycle period
    apb_write('h04, 3); idle(20);
    irq_seen = 0; idle(36);
    chk(irq_seen == 2, "R4 irq pulses div3", irq_seen, 2);
    // R4 first advance N clocks after enabling
    apb_write('h00, 0); apb_write('h10, 0); apb_write('h14, 1);
    apb_write('h00, 1);
    idle(1);
    chk(count_o == 0, "R4 no early advance", int'(count_o), 0);
    idle(2);
    chk(count_o == 1, "R4 first advance", int'(count_o), 1);

    // R3 hold while disabled
    apb_write('h00, 0);
    held = int'(count_o);
    idle(10);
    chk(int'(count_o) == held, "R3 hold", int'(count_o), held);

    // R7 threshold extremes
    apb_write('h04, 0); apb_write('h0C, 0); apb_write('h00, 1); idle(2);
    pwm_high = 0; idle(20);
    chk(pwm_high == 0, "R7 zero threshold", pwm_high, 0);
    apb_write('h0C, 6); idle(2);
    pwm_high = 0; idle(20);
    chk(pwm_high == 20, "R7 high threshold", pwm_high, 20);

    // R8 / R9 load while advancing, preset equal to terminal
    apb_write('h10, 5);
    apb_write('h14, 1);
    chk(count_o == 5, "R9 load wins", int'(count_o), 5);
    chk(!irq_o, "R9 no irq on load", int'(irq_o), 0);
    apb_write('h10, 2); apb_write('h14, 0);
    apb_write('h00, 0); apb_write('h14, 1);
    chk(count_o == 2, "R8 load disabled", int'(count_o), 2);

    // random register traffic
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 5))
        0: apb_write('h00, int'($urandom_range(0, 3)));
        1: apb_write('h04, int'($urandom_range(0, 4)));
        2: apb_write('h08, int'($urandom_range(0, 12)));
        3: apb_write('h0C, int'($urandom_range(0, 14)));
        4: begin
          apb_write('h10, int'($urandom_range(0, 20)));
          apb_write('h14, int'($urandom_range(0, 1)));
        end
        default: begin
          a = int'($urandom_range(0, 7)) * 4;
          apb_read(a, "R2 random read");
        end
      endcase
      idle(int'($urandom_range(0, 6)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule